// File: doc/BRIEF.md
# Folded Reed-Solomon Systematic Encoder

This block turns a stream of information symbols into systematic Reed-Solomon codewords over GF(2^m). Each accepted information symbol is forwarded unchanged to the output and is also folded into a parity shift register built from the code's generator polynomial. Once a full block of information symbols has been taken, the block emits 2t parity symbols, so that every codeword holds n = k + 2t symbols. The generator polynomial has the roots alpha^0 through alpha^(2t-1). Its coefficients are worked out at elaboration from the symbol width and the number of parity symbols.

The parity register can share its finite-field multipliers across several clock cycles. With a folding factor F, only 2t/F multipliers are built. Each accepted symbol then takes F cycles to fold in, and the input ready signal is held low for the cycles in between. Both the input and the output use valid/ready handshakes. The input carries a start-of-block flag that can abandon a partial block. The output marks the first and the last symbol of each codeword. A shortened code is obtained simply by choosing a smaller k, because the missing leading symbols count as zeros.

Top module: `rs_encoder`

## Requirements
- R1: After reset the output is empty (m_valid = 0) and the input is ready (s_ready = 1).
- R2: The first k output symbols of a codeword are the accepted information symbols, unchanged and in the order they were accepted. The first of them carries m_sob = 1 and the others carry m_sob = 0.
- R3: Each codeword ends with 2t parity symbols, for n = k + 2t symbols in all, and m_eob = 1 only on the last one. Take the first output symbol as the coefficient of x^(n-1). The codeword polynomial then evaluates to zero at alpha^i for i = 0 to 2t-1, where alpha = 2 and the field polynomial is x^8+x^4+x^3+x^2+1 (0x11D) for m = 8.
- R4: With folding factor F, s_ready is low for the F-1 cycles after each accepted symbol. With the input always valid and the output always ready, information symbols are accepted exactly every F cycles.
- R5: No information symbol is accepted while parity is being emitted. The first symbol of the next block is accepted no earlier than the cycle in which the previous block's m_eob symbol is taken.
- R6: While m_valid = 1 and m_ready = 0, the values of m_data, m_sob and m_eob do not change in the next cycle, and m_valid stays high.
- R7: An input symbol accepted with s_sob = 1 abandons any partial block. That symbol is output with m_sob = 1 as the first information symbol of a new block, and the parity depends only on the new block.
- R8: A block whose information symbols are all zero produces parity symbols that are all zero.
- R9: Codewords sent back to back are independent. Each one separately meets R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Information symbol is present |
| s_ready | output | 1 | Encoder accepts the symbol this cycle |
| s_sob | input | 1 | Symbol starts a new block (abandons a partial block) |
| s_data | input | SYM_W | Information symbol |
| m_valid | output | 1 | Output symbol is present |
| m_ready | input | 1 | Downstream takes the output symbol |
| m_data | output | SYM_W | Codeword symbol (information or parity) |
| m_sob | output | 1 | First symbol of a codeword |
| m_eob | output | 1 | Last symbol of a codeword |

## Verification
An accepted information symbol appears on the output registers one cycle after its accept edge. Parity emission starts only after the last information symbol's F fold cycles have finished, and then one parity symbol is produced per free output slot. For this reason the bench does not predict absolute output cycles. It records every handshake, on both sides, at a point 1 ns after the falling edge, when inputs and outputs have settled. It then checks order, marks, codeword roots and the spacing of accept cycles, which must equal F when nothing stalls (R4). It also checks that the next block's first accept is not earlier than the previous eob handshake (R5). Stall stability (R6) is checked at each sample by comparing against the previous sample.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  typedef enum logic {PH_INFO, PH_PAR} phase_t;

  // field polynomial for each supported symbol width, bit m included
  function automatic logic [8:0] field_poly(int m);
    case (m)
      4:       return 9'h013;
      7:       return 9'h089;
      default: return 9'h11D;
    endcase
  endfunction

  // shift-and-add multiply in GF(2^m), operands held in 8 bits
  function automatic logic [7:0] gf_mul(logic [7:0] a, logic [7:0] b, int m);
    logic [7:0] acc;
    logic [7:0] sh;
    logic [7:0] mask;
    logic [8:0] p;
    acc  = '0;
    sh   = a;
    p    = field_poly(m);
    mask = 8'((9'd1 << m) - 9'd1);
    for (int i = 0; i < 8; i++) begin
      if (i < m && b[i]) acc = acc ^ sh;
      if (sh[m-1]) sh = ((sh << 1) ^ p[7:0]) & mask;
      else         sh = (sh << 1) & mask;
    end
    return acc & mask;
  endfunction

endpackage

// File: rtl/rs_gf_mul.sv
module rs_gf_mul #(
  parameter int M = 8
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] p_o
);
  import rs_enc_pkg::*;

  logic [7:0] full;

  always_comb begin
    full = gf_mul(8'(a_i), 8'(b_i), M);
    p_o  = full[M-1:0];
  end

endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr #(
  parameter int M    = 8,
  parameter int NPAR = 4,
  parameter int FOLD = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [M-1:0] fb_i,
  input  logic         clr_i,
  input  logic         shift_i,
  output logic         busy_o,
  output logic [M-1:0] top_o
);
  import rs_enc_pkg::*;

  localparam int P    = NPAR / FOLD;
  localparam int FC_W = (FOLD > 1) ? $clog2(FOLD) : 1;

  function automatic logic [M-1:0] fmul(logic [M-1:0] x, logic [M-1:0] y);
    logic [7:0] r;
    r = gf_mul(8'(x), 8'(y), M);
    return r[M-1:0];
  endfunction

  // coefficients of prod (x + alpha^i), i = 0..NPAR-1; leading 1 implied
  function automatic logic [NPAR*M-1:0] gen_coefs();
    logic [M-1:0] g [NPAR+1];
    logic [M-1:0] root;
    logic [NPAR*M-1:0] packed_g;
    for (int j = 0; j <= NPAR; j++) g[j] = '0;
    g[0] = M'(1);
    root = M'(1);
    for (int i = 0; i < NPAR; i++) begin
      for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ fmul(root, g[j]);
      g[0] = fmul(root, g[0]);
      root = fmul(root, M'(2));
    end
    for (int j = 0; j < NPAR; j++) packed_g[j*M +: M] = g[j];
    return packed_g;
  endfunction

  localparam logic [NPAR*M-1:0] GPACK = gen_coefs();

  logic [M-1:0]    par_q [NPAR];
  logic [M-1:0]    below [NPAR];
  logic [FC_W-1:0] fc_q;
  logic [M-1:0]    fb_q;
  logic            clr_q;

  logic            active;
  logic [FC_W-1:0] cur_fc;
  logic [M-1:0]    cur_fb;
  logic            cur_clr;
  int              base;
  logic [M-1:0]    coef_sel [P];
  logic [M-1:0]    prod [P];

  assign busy_o = (fc_q != '0);
  assign top_o  = par_q[NPAR-1];
  assign active = load_i || busy_o;

  always_comb begin
    cur_fc  = load_i ? '0 : fc_q;
    cur_fb  = load_i ? fb_i : fb_q;
    cur_clr = load_i ? clr_i : clr_q;
    // slices are visited from the top register downward
    base    = (FOLD - 1 - int'(cur_fc)) * P;
    for (int j = 0; j < P; j++) coef_sel[j] = GPACK[(base + j)*M +: M];
    below[0] = '0;
    for (int i = 1; i < NPAR; i++) below[i] = par_q[i-1];
  end

  for (genvar j = 0; j < P; j++) begin : g_mul
    rs_gf_mul #(.M(M)) u_mul (
      .a_i (cur_fb),
      .b_i (coef_sel[j]),
      .p_o (prod[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
      fc_q  <= '0;
      fb_q  <= '0;
      clr_q <= 1'b0;
    end else if (shift_i) begin
      par_q[0] <= '0;
      for (int i = 1; i < NPAR; i++) par_q[i] <= par_q[i-1];
    end else if (active) begin
      for (int j = 0; j < P; j++)
        par_q[base + j] <= prod[j] ^ (cur_clr ? '0 : below[base + j]);
      if (load_i) begin
        fb_q  <= fb_i;
        clr_q <= clr_i;
        fc_q  <= (FOLD > 1) ? FC_W'(1) : '0;
      end else begin
        fc_q  <= (fc_q == FC_W'(FOLD - 1)) ? '0 : fc_q + FC_W'(1);
      end
    end
  end

endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
  parameter int M    = 8,
  parameter int K    = 251,
  parameter int NPAR = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  input  logic         s_sob,
  input  logic [M-1:0] s_data,
  output logic         s_ready,
  input  logic         m_ready,
  output logic         m_valid,
  output logic [M-1:0] m_data,
  output logic         m_sob,
  output logic         m_eob,
  input  logic         busy_i,
  input  logic [M-1:0] top_i,
  output logic         load_o,
  output logic [M-1:0] fb_o,
  output logic         clr_o,
  output logic         shift_o
);
  import rs_enc_pkg::*;

  localparam int IC_W = $clog2(K + 1);
  localparam int PC_W = $clog2(NPAR + 1);

  phase_t          phase_q;
  logic [IC_W-1:0] info_cnt;
  logic [IC_W-1:0] info_next;
  logic [PC_W-1:0] par_cnt;
  logic            out_free;
  logic            par_last;

  assign out_free  = !m_valid || m_ready;
  assign s_ready   = (phase_q == PH_INFO) && !busy_i && out_free;
  assign load_o    = s_valid && s_ready;
  assign clr_o     = s_sob || (info_cnt == '0);
  assign fb_o      = s_data ^ (clr_o ? '0 : top_i);
  assign shift_o   = (phase_q == PH_PAR) && !busy_i && out_free;
  assign par_last  = (par_cnt == PC_W'(NPAR - 1));
  assign info_next = s_sob ? IC_W'(1) : info_cnt + IC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_INFO;
      info_cnt <= '0;
      par_cnt  <= '0;
      m_valid  <= 1'b0;
      m_data   <= '0;
      m_sob    <= 1'b0;
      m_eob    <= 1'b0;
    end else if (load_o) begin
      m_valid <= 1'b1;
      m_data  <= s_data;
      m_sob   <= clr_o;
      m_eob   <= 1'b0;
      par_cnt <= '0;
      if (info_next == IC_W'(K)) begin
        phase_q  <= PH_PAR;
        info_cnt <= '0;
      end else begin
        info_cnt <= info_next;
      end
    end else if (shift_o) begin
      m_valid <= 1'b1;
      m_data  <= top_i;
      m_sob   <= 1'b0;
      m_eob   <= par_last;
      if (par_last) begin
        phase_q <= PH_INFO;
        par_cnt <= '0;
      end else begin
        par_cnt <= par_cnt + PC_W'(1);
      end
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rs_encoder.sv
module rs_encoder #(
  parameter int SYM_W  = 8,
  parameter int T_CORR = 2,
  parameter int K_INFO = 251,
  parameter int FOLD   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_sob,
  input  logic [SYM_W-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [SYM_W-1:0] m_data,
  output logic             m_sob,
  output logic             m_eob
);

  localparam int NPAR  = 2 * T_CORR;
  localparam int N_LEN = K_INFO + NPAR;

  logic             load;
  logic [SYM_W-1:0] fb;
  logic             clr;
  logic             shift;
  logic             busy;
  logic [SYM_W-1:0] top;

  rs_enc_ctrl #(.M(SYM_W), .K(K_INFO), .NPAR(NPAR)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_sob   (s_sob),
    .s_data  (s_data),
    .s_ready (s_ready),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_data  (m_data),
    .m_sob   (m_sob),
    .m_eob   (m_eob),
    .busy_i  (busy),
    .top_i   (top),
    .load_o  (load),
    .fb_o    (fb),
    .clr_o   (clr),
    .shift_o (shift)
  );

  rs_parity_lfsr #(.M(SYM_W), .NPAR(NPAR), .FOLD(FOLD)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .fb_i    (fb),
    .clr_i   (clr),
    .shift_i (shift),
    .busy_o  (busy),
    .top_o   (top)
  );

endmodule

// File: rtl/rs_encoder_chk.sv
module rs_encoder_chk #(
  parameter int SYM_W  = 8,
  parameter int K_INFO = 251,
  parameter int NPAR   = 4,
  parameter int FOLD   = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_sob,
  input logic             m_valid,
  input logic             m_ready,
  input logic [SYM_W-1:0] m_data,
  input logic             m_sob,
  input logic             m_eob
);

  int   out_cnt;
  int   in_cnt;
  logic rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst) begin
      out_cnt <= 0;
      in_cnt  <= 0;
    end else begin
      if (m_valid && m_ready) begin
        if (m_eob)      out_cnt <= 0;
        else if (m_sob) out_cnt <= 1;
        else            out_cnt <= out_cnt + 1;
      end
      if (s_valid && s_ready && s_sob)        in_cnt <= 1;
      else if (m_valid && m_eob)              in_cnt <= (s_valid && s_ready) ? 1 : 0;
      else if (s_valid && s_ready)            in_cnt <= in_cnt + 1;
    end
  end

  // R1: registers cleared one edge after reset
  always_ff @(posedge clk) begin
    if (rst_seen == 1'b1 && !rst)
      p_reset_r1: assert (!m_valid && s_ready);
  end

  p_throttle_r4: assert property (@(posedge clk) disable iff (rst)
    (FOLD > 1 && s_valid && s_ready) |=> !s_ready);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sob) && $stable(m_eob)));

  p_marks_r3: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !(m_sob && m_eob));

  p_len_r3: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_eob) |-> (out_cnt == K_INFO + NPAR - 1));

  p_inlimit_r5: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && !s_sob && !(m_valid && m_eob)) |-> (in_cnt < K_INFO));

endmodule

bind rs_encoder rs_encoder_chk #(
  .SYM_W(SYM_W), .K_INFO(K_INFO), .NPAR(NPAR), .FOLD(FOLD)
) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_sob(s_sob),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sob(m_sob), .m_eob(m_eob)
);

// File: tb/rs_encoder_test.sv
`timescale 1ns/1ps
module rs_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int K    = 11;
  localparam int NP   = 4;
  localparam int N    = K + NP;
  localparam int FOLD = 2;

  logic       clk = 0;
  logic       rst;
  logic       s_valid, s_sob;
  logic [7:0] s_data;
  logic       s_ready;
  logic       m_valid, m_ready;
  logic [7:0] m_data;
  logic       m_sob, m_eob;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  int oq_d[$];
  bit oq_s[$];
  bit oq_e[$];
  int oq_c[$];
  int acc_c[$];

  int   stall_seen, stall_err;
  logic prev_stall;
  logic [7:0] prev_d;
  logic prev_s, prev_e;

  rs_encoder #(.SYM_W(8), .T_CORR(2), .K_INFO(K), .FOLD(FOLD)) uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_sob(s_sob),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sob(m_sob), .m_eob(m_eob)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, sampled after inputs and outputs have settled
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (prev_stall) begin
        stall_seen++;
        if (!m_valid || m_data != prev_d || m_sob != prev_s || m_eob != prev_e) stall_err++;
      end
      prev_stall = m_valid && !m_ready;
      prev_d = m_data; prev_s = m_sob; prev_e = m_eob;
      if (m_valid && m_ready) begin
        oq_d.push_back(int'(m_data));
        oq_s.push_back(m_sob);
        oq_e.push_back(m_eob);
        oq_c.push_back(cyc);
      end
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    int r = 0;
    int x = a;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) r = r ^ x;
      x = x << 1;
      if (x & 256) x = x ^ 'h11D;
    end
    return r;
  endfunction

  task automatic send(input int d, input bit sob);
    s_valid = 1'b1; s_data = 8'(d); s_sob = sob;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    acc_c.push_back(cyc);
    @(negedge clk);
    s_valid = 1'b0; s_sob = 1'b0;
  endtask

  task automatic clear_q();
    oq_d.delete(); oq_s.delete(); oq_e.delete(); oq_c.delete(); acc_c.delete();
  endtask

  task automatic wait_out(input int n, input string req);
    int t = 0;
    while (oq_d.size() < n && t < 3000) begin @(negedge clk); t++; end
    repeat (12) @(negedge clk);
    chk(oq_d.size() == n, req, oq_d.size(), n, "output symbol count");
  endtask

  // info passthrough, marks and codeword roots for the codeword at index st
  task automatic check_cw(input int st, input int dat[], input string tag);
    int bad_d = 0, bad_m = 0;
    if (oq_d.size() < st + N) begin
      chk(0, tag, oq_d.size(), st + N, "codeword missing");
      return;
    end
    for (int i = 0; i < K; i++) if (oq_d[st+i] != dat[i]) bad_d++;
    chk(bad_d == 0, "R2", bad_d, 0, {tag, " info symbol mismatches"});
    for (int i = 0; i < N; i++) begin
      if (oq_s[st+i] != (i == 0)) bad_m++;
    end
    chk(bad_m == 0, "R2", bad_m, 0, {tag, " sob mark errors"});
    bad_m = 0;
    for (int i = 0; i < N; i++) if (oq_e[st+i] != (i == N-1)) bad_m++;
    chk(bad_m == 0, "R3", bad_m, 0, {tag, " eob mark errors"});
    for (int r = 0; r < NP; r++) begin
      int x = 1, s = 0;
      for (int e = 0; e < r; e++) x = gmul(x, 2);
      for (int i = 0; i < N; i++) s = gmul(s, x) ^ oq_d[st+i];
      chk(s == 0, "R3", s, 0, $sformatf("%s codeword at alpha^%0d", tag, r));
    end
  endtask

  task automatic t_reset();
    rst = 1; s_valid = 0; s_sob = 0; s_data = 0; m_ready = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(m_valid == 1'b0, "R1", m_valid, 0, "m_valid after reset");
    chk(s_ready == 1'b1, "R1", s_ready, 1, "s_ready after reset");
    @(negedge clk);
  endtask

  task automatic t_basic();
    int d[] = new[K];
    int bad = 0;
    clear_q();
    for (int i = 0; i < K; i++) d[i] = (i*37 + 5) & 255;
    for (int i = 0; i < K; i++) send(d[i], i == 0);
    wait_out(N, "R3");
    check_cw(0, d, "basic");
    for (int i = 1; i < K; i++) if (acc_c[i] - acc_c[i-1] != FOLD) bad++;
    chk(bad == 0, "R4", bad, 0, "accept spacing not equal to FOLD");
  endtask

  task automatic t_zero();
    int d[] = new[K];
    int nz = 0;
    clear_q();
    for (int i = 0; i < K; i++) d[i] = 0;
    for (int i = 0; i < K; i++) send(0, 1'b0);
    wait_out(N, "R8");
    for (int i = K; i < N && i < oq_d.size(); i++) if (oq_d[i] != 0) nz++;
    chk(nz == 0, "R8", nz, 0, "nonzero parity symbols for zero block");
    check_cw(0, d, "zero");
  endtask

  task automatic t_stall();
    int d[] = new[K];
    clear_q();
    stall_seen = 0; stall_err = 0;
    for (int i = 0; i < K; i++) d[i] = (i*113 + 77) & 255;
    fork
      for (int i = 0; i < K; i++) send(d[i], 1'b0);
      begin
        int p = 0;
        while (oq_d.size() < N && p < 2000) begin
          m_ready = ((p % 5) == 1) || ((p % 5) == 3);
          @(negedge clk);
          p++;
        end
        m_ready = 1'b1;
      end
    join
    wait_out(N, "R6");
    chk(stall_seen > 0, "R6", stall_seen, 1, "stalled cycles observed");
    chk(stall_err == 0, "R6", stall_err, 0, "output changed while stalled");
    check_cw(0, d, "stall");
  endtask

  task automatic t_back2back();
    int a[] = new[K];
    int b[] = new[K];
    clear_q();
    for (int i = 0; i < K; i++) begin a[i] = (i*91 + 200) & 255; b[i] = (i*19 + 3) & 255; end
    for (int i = 0; i < K; i++) send(a[i], 1'b0);
    for (int i = 0; i < K; i++) send(b[i], 1'b0);
    wait_out(2*N, "R9");
    if (acc_c.size() == 2*K && oq_c.size() >= N)
      chk(acc_c[K] >= oq_c[N-1], "R5", acc_c[K], oq_c[N-1], "next block accepted before eob taken");
    else
      chk(0, "R5", acc_c.size(), 2*K, "accept records");
    check_cw(0, a, "b2b first");
    check_cw(N, b, "b2b second R9");
  endtask

  task automatic t_abort();
    int d[] = new[K];
    int ns = 0;
    clear_q();
    for (int i = 0; i < 3; i++) send((i*7 + 9) & 255, 1'b0);
    for (int i = 0; i < K; i++) d[i] = (i*53 + 31) & 255;
    for (int i = 0; i < K; i++) send(d[i], i == 0);
    wait_out(3 + N, "R7");
    for (int i = 0; i < oq_s.size(); i++) if (oq_s[i]) ns++;
    chk(ns == 2 && oq_s.size() > 3 && oq_s[0] && oq_s[3], "R7", ns, 2, "sob marks around abort");
    check_cw(3, d, "abort R7");
  endtask

  initial begin
    prev_stall = 1'b0;
    t_reset();
    t_basic();
    t_zero();
    t_stall();
    t_back2back();
    t_abort();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule